// File: doc/BRIEF.md
# Register Rename Instance Counters

This block keeps two small counters per architectural register of an out-of-order core. One counts the writers of that register that are still in flight. The other holds the version number given to the newest of those writers. The register index joined with the version number is a rename tag. Consumers wait on that tag instead of on the bare register index, so several pending writes to one register stay apart.

A dispatch port takes the destination register of a new instruction. In the same cycle it returns the tag of the new instance, or it raises a stall if that register already has as many writers in flight as the counter can hold. Source lookup ports return the current tag of any register. A commit port retires the oldest in-flight instance of one register. When the last instance retires, the version counter returns to zero.

Top module: `rntag_top`

## Requirements
- R1: After reset every instance count and every version counter is zero, so a lookup of register r returns the tag r*2^CNT_W (version 0), and the stall output is low.
- R2: A dispatch request (disp_valid high) that is not stalled raises the destination's instance count and version by one each at the next clock edge. In the same cycle, disp_tag shows the destination register with the incremented version.
- R3: disp_stall goes high combinationally exactly when disp_valid is high and the destination's instance count equals 2^CNT_W-1. A stalled request changes no state, and disp_stall is low whenever disp_valid is low.
- R4: A commit (cmt_valid high) to a register with a nonzero count lowers that count by one. If the count stays above zero, the version is left unchanged.
- R5: When a commit brings a register's count to zero, its version is cleared to zero, so the next dispatch to it returns version 1.
- R6: A commit to a register whose count is already zero is ignored. That register can still take 2^CNT_W-1 dispatches before it stalls.
- R7: A tag is REG_W+CNT_W bits wide. Bits [TAG_W-1:CNT_W] hold the register index and bits [CNT_W-1:0] hold the version.
- R8: A dispatch and a commit to the same register in one cycle leave its count unchanged and raise its version by one, without clearing it. The stall decision uses the count from before the update, so at a full count the commit is still taken and the dispatch is refused.
- R9: Source lookups are combinational and show the state from before the current cycle's update.
- R10: The version counter wraps modulo 2^CNT_W while instances stay in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_reg | input | REG_W | Destination register of the dispatch |
| disp_stall | output | 1 | Dispatch refused: destination is full |
| disp_tag | output | TAG_W | Tag of the new instance |
| cmt_valid | input | 1 | Commit request |
| cmt_reg | input | REG_W | Register whose oldest instance retires |
| src_reg | input | NSRC*REG_W | Lookup register indices, port k in bits [k*REG_W +: REG_W] |
| src_tag | output | NSRC*TAG_W | Current tags, port k in bits [k*TAG_W +: TAG_W] |

## Verification
Dispatch and commit can act in the same cycle, either on one register or on two different ones. The bench drives both requests in one cycle: on the same register at a moderate count, on the same register at a full count, at a count of one, and on two different registers. It then judges the result through the lookup ports and through later stall behaviour. A version that was not cleared, or a count that stayed the same, shows up as a tag value or as a stall that comes one dispatch early or late. The bench compares these against a model built from the requirements.

// File: rtl/rntag_pkg.sv
package rntag_pkg;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_INC  = 2'd1,
    UPD_DEC  = 2'd2,
    UPD_SWAP = 2'd3
  } upd_e;

  // Kind of update an entry sees this cycle; dec must already be qualified
  function automatic upd_e classify(input logic inc, input logic dec);
    unique case ({inc, dec})
      2'b10:   return UPD_INC;
      2'b01:   return UPD_DEC;
      2'b11:   return UPD_SWAP;
      default: return UPD_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/rntag_entry.sv
module rntag_entry #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lat
);
  import rntag_pkg::*;

  upd_e kind;
  logic dec_ok;
  logic drain;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c, input upd_e k);
    case (k)
      UPD_INC: return c + 1'b1;
      UPD_DEC: return c - 1'b1;
      default: return c;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] lat_next(input logic [CNT_W-1:0] l, input upd_e k,
                                                input logic last);
    if (k == UPD_INC || k == UPD_SWAP) return l + 1'b1;
    if (last) return '0;
    return l;
  endfunction

  assign dec_ok = dec && (cnt != '0);
  assign kind   = classify(inc, dec_ok);
  assign drain  = (kind == UPD_DEC) && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      lat <= '0;
    end else begin
      cnt <= cnt_next(cnt, kind);
      lat <= lat_next(lat, kind, drain);
    end
  end
endmodule

// File: rtl/rntag_dispatch.sv
module rntag_dispatch #(
  parameter int NREG  = 32,
  parameter int REG_W = 5,
  parameter int CNT_W = 3
) (
  input  logic                    disp_valid,
  input  logic [REG_W-1:0]        disp_reg,
  input  logic                    cmt_valid,
  input  logic [REG_W-1:0]        cmt_reg,
  input  logic [NREG*CNT_W-1:0]   cnt_vec,
  input  logic [NREG*CNT_W-1:0]   lat_vec,
  output logic                    stall,
  output logic                    fire,
  output logic [NREG-1:0]         inc_vec,
  output logic [NREG-1:0]         dec_vec,
  output logic [REG_W+CNT_W-1:0]  tag
);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic [CNT_W-1:0] d_cnt;
  logic [CNT_W-1:0] d_lat;

  function automatic logic [REG_W+CNT_W-1:0] make_tag(input logic [REG_W-1:0] r,
                                                      input logic [CNT_W-1:0] v);
    return {r, v};
  endfunction

  assign d_cnt = cnt_vec[disp_reg*CNT_W +: CNT_W];
  assign d_lat = lat_vec[disp_reg*CNT_W +: CNT_W];
  assign stall = disp_valid && (d_cnt == MAXC);
  assign fire  = disp_valid && !stall;
  assign tag   = make_tag(disp_reg, d_lat + 1'b1);

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign inc_vec[i] = fire && (disp_reg == REG_W'(i));
    assign dec_vec[i] = cmt_valid && (cmt_reg == REG_W'(i));
  end
endmodule

// File: rtl/rntag_lookup.sv
module rntag_lookup #(
  parameter int NREG  = 32,
  parameter int REG_W = 5,
  parameter int CNT_W = 3,
  parameter int NSRC  = 2
) (
  input  logic [NSRC*REG_W-1:0]         src_reg,
  input  logic [NREG*CNT_W-1:0]         lat_vec,
  output logic [NSRC*(REG_W+CNT_W)-1:0] src_tag
);
  localparam int TAG_W = REG_W + CNT_W;

  for (genvar k = 0; k < NSRC; k++) begin : g_port
    logic [REG_W-1:0] r;
    assign r = src_reg[k*REG_W +: REG_W];
    assign src_tag[k*TAG_W +: TAG_W] = {r, lat_vec[r*CNT_W +: CNT_W]};
  end
endmodule

// File: rtl/rntag_top.sv
module rntag_top #(
  parameter int NREG  = 32,
  parameter int CNT_W = 3,
  parameter int NSRC  = 2,
  parameter int REG_W = $clog2(NREG),
  parameter int TAG_W = REG_W + CNT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_valid,
  input  logic [REG_W-1:0]      disp_reg,
  output logic                  disp_stall,
  output logic [TAG_W-1:0]      disp_tag,
  input  logic                  cmt_valid,
  input  logic [REG_W-1:0]      cmt_reg,
  input  logic [NSRC*REG_W-1:0] src_reg,
  output logic [NSRC*TAG_W-1:0] src_tag
);
  logic [NREG*CNT_W-1:0] cnt_vec;
  logic [NREG*CNT_W-1:0] lat_vec;
  logic [NREG-1:0]       inc_vec;
  logic [NREG-1:0]       dec_vec;
  logic                  disp_fire;

  rntag_dispatch #(.NREG(NREG), .REG_W(REG_W), .CNT_W(CNT_W)) u_disp (
    .disp_valid (disp_valid),
    .disp_reg   (disp_reg),
    .cmt_valid  (cmt_valid),
    .cmt_reg    (cmt_reg),
    .cnt_vec    (cnt_vec),
    .lat_vec    (lat_vec),
    .stall      (disp_stall),
    .fire       (disp_fire),
    .inc_vec    (inc_vec),
    .dec_vec    (dec_vec),
    .tag        (disp_tag)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    rntag_entry #(.CNT_W(CNT_W)) u_ent (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_vec[i]),
      .dec   (dec_vec[i]),
      .cnt   (cnt_vec[i*CNT_W +: CNT_W]),
      .lat   (lat_vec[i*CNT_W +: CNT_W])
    );
  end

  rntag_lookup #(.NREG(NREG), .REG_W(REG_W), .CNT_W(CNT_W), .NSRC(NSRC)) u_look (
    .src_reg (src_reg),
    .lat_vec (lat_vec),
    .src_tag (src_tag)
  );
endmodule

// File: rtl/rntag_chk.sv
module rntag_chk #(
  parameter int NREG  = 32,
  parameter int CNT_W = 3,
  parameter int REG_W = $clog2(NREG),
  parameter int TAG_W = REG_W + CNT_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   disp_valid,
  input logic [REG_W-1:0]       disp_reg,
  input logic                   disp_stall,
  input logic [TAG_W-1:0]       disp_tag,
  input logic                   disp_fire,
  input logic                   cmt_valid,
  input logic [REG_W-1:0]       cmt_reg,
  input logic [NREG*CNT_W-1:0]  cnt_vec,
  input logic [NREG*CNT_W-1:0]  lat_vec
);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  logic [CNT_W-1:0] sel_cnt;
  logic [CNT_W-1:0] cmt_cnt;
  logic             p_fire;
  logic             p_swap;
  logic [REG_W-1:0] p_reg;
  logic [CNT_W-1:0] p_ver;
  logic [CNT_W-1:0] p_cnt;
  logic [CNT_W-1:0] now_cnt;
  logic [CNT_W-1:0] now_lat;

  assign sel_cnt = cnt_vec[disp_reg*CNT_W +: CNT_W];
  assign cmt_cnt = cnt_vec[cmt_reg*CNT_W +: CNT_W];
  assign now_cnt = cnt_vec[p_reg*CNT_W +: CNT_W];
  assign now_lat = lat_vec[p_reg*CNT_W +: CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_fire <= 1'b0;
      p_swap <= 1'b0;
      p_reg  <= '0;
      p_ver  <= '0;
      p_cnt  <= '0;
    end else begin
      p_fire <= disp_fire;
      p_swap <= disp_fire && cmt_valid && (cmt_reg == disp_reg) && (cmt_cnt != '0);
      p_reg  <= disp_reg;
      p_ver  <= disp_tag[CNT_W-1:0];
      p_cnt  <= sel_cnt;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |-> (disp_valid && sel_cnt == MAXC));

  a_r3_accept_below_max: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && sel_cnt != MAXC) |-> disp_fire);

  a_r7_tag_index: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |-> (disp_tag[TAG_W-1:CNT_W] == disp_reg));

  a_r2_version_stored: assert property (@(posedge clk) disable iff (!rst_n)
    p_fire |-> (now_lat == p_ver));

  a_r8_swap_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    p_swap |-> (now_cnt == p_cnt));

  for (genvar i = 0; i < NREG; i++) begin : g_idle
    a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_vec[i*CNT_W +: CNT_W] == '0) |-> (lat_vec[i*CNT_W +: CNT_W] == '0));
  end
endmodule

bind rntag_top rntag_chk #(.NREG(NREG), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_valid (disp_valid),
  .disp_reg   (disp_reg),
  .disp_stall (disp_stall),
  .disp_tag   (disp_tag),
  .disp_fire  (disp_fire),
  .cmt_valid  (cmt_valid),
  .cmt_reg    (cmt_reg),
  .cnt_vec    (cnt_vec),
  .lat_vec    (lat_vec)
);

// File: tb/rntag_top_test.sv
`timescale 1ns/1ps
module rntag_top_test;
  localparam int NREG = 32, CNT_W = 3, NSRC = 2, REG_W = 5, TAG_W = 8;
  localparam int VMOD = 8, FULL = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic [REG_W-1:0] disp_reg = '0;
  logic disp_stall;
  logic [TAG_W-1:0] disp_tag;
  logic cmt_valid = 1'b0;
  logic [REG_W-1:0] cmt_reg = '0;
  logic [NSRC*REG_W-1:0] src_reg = '0;
  logic [NSRC*TAG_W-1:0] src_tag;

  int checks = 0, fails = 0;
  int m_cnt [NREG];
  int m_ver [NREG];
  bit done = 0;

  always #5 clk = ~clk;

  rntag_top #(.NREG(NREG), .CNT_W(CNT_W), .NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_reg(disp_reg),
    .disp_stall(disp_stall), .disp_tag(disp_tag), .cmt_valid(cmt_valid),
    .cmt_reg(cmt_reg), .src_reg(src_reg), .src_tag(src_tag));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tag_of(int r, int v);
    return r * VMOD + (v % VMOD);
  endfunction

  // One cycle of dispatch/commit stimulus with same-cycle output checks
  task automatic drive(bit dv, int dr, bit cv, int cr, string req);
    bit exp_stall, inc, dec;
    @(negedge clk);
    disp_valid = dv; disp_reg = REG_W'(dr);
    cmt_valid = cv;  cmt_reg = REG_W'(cr);
    src_reg[REG_W +: REG_W] = REG_W'(dr);
    #2;
    exp_stall = dv && (m_cnt[dr] == FULL);
    check({req, " R3 stall"}, int'(disp_stall), int'(exp_stall));
    if (dv && !exp_stall)
      check({req, " R2 R7 dispatch tag"}, int'(disp_tag), tag_of(dr, m_ver[dr] + 1));
    check({req, " R9 pre-update lookup"}, int'(src_tag[TAG_W +: TAG_W]), tag_of(dr, m_ver[dr]));
    @(posedge clk);
    inc = dv && !exp_stall;
    dec = cv && (m_cnt[cr] != 0);
    if (inc) begin m_cnt[dr] += 1; m_ver[dr] = (m_ver[dr] + 1) % VMOD; end
    if (dec) begin
      m_cnt[cr] -= 1;
      if (m_cnt[cr] == 0) m_ver[cr] = 0;
    end
    #1;
    disp_valid = 1'b0; cmt_valid = 1'b0;
  endtask

  task automatic look(int r, string req);
    @(negedge clk);
    src_reg[0 +: REG_W] = REG_W'(r);
    #1;
    check({req, " lookup"}, int'(src_tag[0 +: TAG_W]), tag_of(r, m_ver[r]));
  endtask

  task automatic t_reset;
    for (int r = 0; r < NREG; r++) look(r, "R1 reset");
    check("R1 R3 stall idle", int'(disp_stall), 0);
  endtask

  task automatic t_basic;
    for (int i = 0; i < 3; i++) drive(1, 5, 0, 0, "R2 basic");
    look(5, "R2 after three");
    drive(1, 31, 0, 0, "R7 top index");
    look(31, "R7 top index");
  endtask

  task automatic t_fill;
    for (int i = 0; i < FULL; i++) drive(1, 9, 0, 0, "R3 fill");
    drive(1, 9, 0, 0, "R3 full refused");
    look(9, "R3 refused no change");
    check("R3 stall low without valid", int'(disp_stall), 0);
  endtask

  task automatic t_commit;
    drive(0, 0, 1, 5, "R4 commit");
    look(5, "R4 version kept");
    drive(0, 0, 1, 5, "R4 commit");
    drive(0, 0, 1, 5, "R5 last commit");
    look(5, "R5 cleared");
    drive(1, 5, 0, 0, "R5 restart version 1");
  endtask

  task automatic t_idle_commit;
    drive(0, 0, 1, 12, "R6 commit on empty");
    look(12, "R6 unchanged");
    for (int i = 0; i < FULL; i++) drive(1, 12, 0, 0, "R6 capacity intact");
    drive(1, 12, 0, 0, "R6 stalls only when full");
  endtask

  task automatic t_same_cycle;
    drive(1, 9, 1, 9, "R8 full with commit");
    look(9, "R8 full with commit");
    drive(1, 9, 1, 9, "R8 swap");
    look(9, "R8 swap version");
    drive(1, 9, 0, 0, "R8 count held");
    drive(1, 9, 0, 0, "R8 count held full");
    drive(1, 3, 0, 0, "R8 single");
    drive(1, 3, 1, 3, "R8 swap at one");
    look(3, "R8 not cleared");
    drive(0, 0, 1, 3, "R5 drain after swap");
    look(3, "R5 drain after swap");
    drive(1, 7, 1, 12, "R2 R4 different regs");
    look(7, "R2 different regs");
    look(12, "R4 different regs");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < FULL; i++) drive(1, 20, 0, 0, "R10 fill");
    drive(0, 0, 1, 20, "R10 commit one");
    drive(1, 20, 0, 0, "R10 wrap to zero");
    look(20, "R10 wrapped");
    drive(1, 20, 0, 0, "R10 after wrap");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) begin m_cnt[r] = 0; m_ver[r] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_fill();
    t_commit();
    t_idle_commit();
    t_same_cycle();
    t_wrap();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule